// File: doc/BRIEF.md
# Two-Level Breakpoint Trigger Unit

This block sits next to a processor core and watches two things: the instruction stream, at one sample point per instruction, and the operand bus cycles. Three comparators look for breakpoint conditions. The first tests the program counter for equality under a mask. The second tests whether an operand address falls inside an inclusive window. The third tests operand data for equality under a mask. Software chooses which comparators feed the first trigger level and which feed the second. A trigger can be single-level, or it can be two-level, where the second level only starts listening once the first level has fired.

When the last level fires, the block carries out the programmed response. It can send a one-cycle halt request to the core. It can instead raise a debug interrupt. That interrupt stays pending until the next instruction sample point and beats the non-maskable level-7 request at that point. The sequencer state appears as a 4-bit code on the debug data nibble, unless trace data is using that nibble. The same code always appears in the top four bits of a status word.

The core asserts `insn_sample` one cycle before the instruction at `pc_in` starts executing. The registered `halt_req` or `take_dbg` from a program-counter match therefore reaches the core before that instruction runs. Address and data triggers may be reported some instructions after the fact.

Top module: `bkpt_trigger_unit`

## Requirements
- R1: After a synchronous reset, the status code is 0000 on `ddata_out` and in `csr_status`, and `halt_req`, `take_dbg` and `take_nmi` are all low.
- R2: A write to offset 0 reloads the trigger control word and restarts the sequencer, and it also drops any pending debug interrupt. The control word fields are: bits [1:0] response, bit 2 two-level, bits [5:3] level-1 enables, bits [8:6] level-2 enables. Within each enable field, bit 0 selects the PC comparator, bit 1 the address comparator and bit 2 the data comparator. The sequencer restarts in the waiting-for-level-1 state if any level-1 enable is set, and in the off state otherwise. The status code is {state, 0}: off 0000, waiting for level 1 0010, level 1 fired 0100, waiting for level 2 1010, level 2 fired 1100. All codes appear one cycle after the clock edge that causes them.
- R3: The PC comparator is evaluated only while `insn_sample` is high. It matches when `pc_in` equals the reference (offset 1) in every bit where the mask (offset 2) is 0. A mask bit of 1 means that bit is ignored.
- R4: The address comparator is evaluated only while `bus_valid` is high. It matches when low bound (offset 3) <= `bus_addr` <= high bound (offset 4).
- R5: The data comparator is evaluated only while `bus_valid` is high. It matches when `bus_data` equals the reference (offset 5) in every bit where the mask (offset 6) is 0.
- R6: In single-level mode, any enabled level-1 comparator match while waiting for level 1 moves the sequencer to the level-1-fired state.
- R7: In two-level mode, a level-1 match moves the sequencer to waiting for level 2. Only after that does a match on an enabled level-2 comparator move it to the level-2-fired state. Level-2 matches seen while waiting for level 1 have no effect.
- R8: A fired final state holds, and further matches cause no further response, until offset 0 is written again.
- R9: With response 1, `halt_req` is high for exactly the one cycle after the edge at which the final level fires.
- R10: With response 2, `take_dbg` pulses for one cycle after the first `insn_sample` edge at or after the firing edge. Before that point the interrupt stays pending.
- R11: `take_nmi` pulses one cycle after an `insn_sample` edge with `ext_nmi` high, except at an edge where the debug interrupt is taken.
- R12: `ddata_out` carries `trace_nib` while `trace_busy` is high and the status code otherwise. `csr_status` carries the status code in its top four bits and zeros elsewhere.
- R13: With response 0 or 3, firing changes the status code only and raises neither `halt_req` nor `take_dbg`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Configuration register offset |
| cfg_wdata | input | REG_W | Configuration write data |
| insn_sample | input | 1 | Instruction boundary sample point |
| pc_in | input | AW | Address of the instruction about to execute |
| bus_valid | input | 1 | Valid operand bus cycle |
| bus_addr | input | AW | Operand address |
| bus_data | input | DW | Operand data |
| ext_nmi | input | 1 | Level-7 non-maskable request |
| trace_busy | input | 1 | Debug nibble is carrying trace data |
| trace_nib | input | 4 | Trace nibble |
| ddata_out | output | 4 | Debug data nibble |
| csr_status | output | REG_W | Status word, code in top four bits |
| halt_req | output | 1 | Halt request pulse |
| take_dbg | output | 1 | Debug interrupt taken pulse |
| take_nmi | output | 1 | Level-7 interrupt taken pulse |

## Verification
The hardest situation to reach is an address or data trigger with interrupt response that stays pending across cycles with no sample point, and is then taken at a sample point where `ext_nmi` is also high. Purely random stimulus seldom lines up a bus match, an armed interrupt response and the right sample timing, so directed steps build this case and its same-cycle counterpart. Long random runs then use small value ranges for addresses, data and PC, so that windows, masks and two-level sequences match often, with reconfiguration happening in the middle of a sequence.

// File: rtl/bkpt_pkg.sv
package bkpt_pkg;
  typedef enum logic [2:0] {
    ST_OFF   = 3'b000,
    ST_WAIT1 = 3'b001,
    ST_HIT1  = 3'b010,
    ST_WAIT2 = 3'b101,
    ST_HIT2  = 3'b110
  } bk_state_e;

  localparam logic [1:0] RESP_HALT = 2'd1;
  localparam logic [1:0] RESP_IRQ  = 2'd2;

  localparam int SRC_PC   = 0;
  localparam int SRC_ADDR = 1;
  localparam int SRC_DATA = 2;
  localparam int N_SRC    = 3;

  localparam logic [2:0] OFS_CTRL   = 3'd0;
  localparam logic [2:0] OFS_PC_REF = 3'd1;
  localparam logic [2:0] OFS_PC_MSK = 3'd2;
  localparam logic [2:0] OFS_A_LO   = 3'd3;
  localparam logic [2:0] OFS_A_HI   = 3'd4;
  localparam logic [2:0] OFS_D_REF  = 3'd5;
  localparam logic [2:0] OFS_D_MSK  = 3'd6;

  typedef struct packed {
    logic [N_SRC-1:0] lvl2_en;
    logic [N_SRC-1:0] lvl1_en;
    logic             two_lvl;
    logic [1:0]       resp;
  } bk_ctrl_t;

  localparam int CTRL_W = $bits(bk_ctrl_t);
endpackage

// File: rtl/bkpt_cfg_regs.sv
module bkpt_cfg_regs
  import bkpt_pkg::*;
#(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int REG_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic [2:0]       cfg_addr,
  input  logic [REG_W-1:0] cfg_wdata,
  output bk_ctrl_t         ctrl,
  output bk_ctrl_t         ctrl_new,
  output logic             restart,
  output logic [AW-1:0]    pc_ref,
  output logic [AW-1:0]    pc_mask,
  output logic [AW-1:0]    addr_lo,
  output logic [AW-1:0]    addr_hi,
  output logic [DW-1:0]    data_ref,
  output logic [DW-1:0]    data_mask
);
  assign ctrl_new = bk_ctrl_t'(cfg_wdata[CTRL_W-1:0]);
  assign restart  = cfg_we && (cfg_addr == OFS_CTRL);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl      <= '0;
      pc_ref    <= '0;
      pc_mask   <= '0;
      addr_lo   <= '0;
      addr_hi   <= '0;
      data_ref  <= '0;
      data_mask <= '0;
    end else if (cfg_we) begin
      case (cfg_addr)
        OFS_CTRL:   ctrl      <= ctrl_new;
        OFS_PC_REF: pc_ref    <= cfg_wdata[AW-1:0];
        OFS_PC_MSK: pc_mask   <= cfg_wdata[AW-1:0];
        OFS_A_LO:   addr_lo   <= cfg_wdata[AW-1:0];
        OFS_A_HI:   addr_hi   <= cfg_wdata[AW-1:0];
        OFS_D_REF:  data_ref  <= cfg_wdata[DW-1:0];
        OFS_D_MSK:  data_mask <= cfg_wdata[DW-1:0];
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/bkpt_match.sv
module bkpt_match
  import bkpt_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic             insn_sample,
  input  logic [AW-1:0]    pc_in,
  input  logic             bus_valid,
  input  logic [AW-1:0]    bus_addr,
  input  logic [DW-1:0]    bus_data,
  input  logic [AW-1:0]    pc_ref,
  input  logic [AW-1:0]    pc_mask,
  input  logic [AW-1:0]    addr_lo,
  input  logic [AW-1:0]    addr_hi,
  input  logic [DW-1:0]    data_ref,
  input  logic [DW-1:0]    data_mask,
  output logic [N_SRC-1:0] hits
);
  logic pc_eq, in_range, data_eq;

  always_comb begin
    pc_eq    = ((pc_in ^ pc_ref) & ~pc_mask) == '0;
    in_range = (bus_addr >= addr_lo) && (bus_addr <= addr_hi);
    data_eq  = ((bus_data ^ data_ref) & ~data_mask) == '0;
    hits           = '0;
    hits[SRC_PC]   = insn_sample && pc_eq;
    hits[SRC_ADDR] = bus_valid && in_range;
    hits[SRC_DATA] = bus_valid && data_eq;
  end
endmodule

// File: rtl/bkpt_seq.sv
module bkpt_seq
  import bkpt_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  input  bk_ctrl_t         ctrl_new,
  input  bk_ctrl_t         ctrl,
  input  logic [N_SRC-1:0] hits,
  input  logic             insn_sample,
  input  logic             ext_nmi,
  input  logic             trace_busy,
  input  logic [3:0]       trace_nib,
  output logic [3:0]       code,
  output logic [3:0]       ddata_out,
  output logic             halt_req,
  output logic             take_dbg,
  output logic             take_nmi
);
  bk_state_e state_q, state_d;
  logic pend_q, pend_d;
  logic lvl1, lvl2, fire, irq_fire, take_now;

  always_comb begin
    lvl1    = |(hits & ctrl.lvl1_en);
    lvl2    = |(hits & ctrl.lvl2_en);
    state_d = state_q;
    fire    = 1'b0;
    if (restart) begin
      state_d = (|ctrl_new.lvl1_en) ? ST_WAIT1 : ST_OFF;
    end else begin
      case (state_q)
        ST_WAIT1: if (lvl1) begin
          if (ctrl.two_lvl) state_d = ST_WAIT2;
          else begin
            state_d = ST_HIT1;
            fire    = 1'b1;
          end
        end
        ST_WAIT2: if (lvl2) begin
          state_d = ST_HIT2;
          fire    = 1'b1;
        end
        default: ;
      endcase
    end
    irq_fire = fire && (ctrl.resp == RESP_IRQ);
    take_now = !restart && insn_sample && (pend_q || irq_fire);
    pend_d   = restart ? 1'b0 : ((pend_q || irq_fire) && !take_now);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_OFF;
      pend_q    <= 1'b0;
      code      <= '0;
      ddata_out <= '0;
      halt_req  <= 1'b0;
      take_dbg  <= 1'b0;
      take_nmi  <= 1'b0;
    end else begin
      state_q   <= state_d;
      pend_q    <= pend_d;
      code      <= {state_d, 1'b0};
      ddata_out <= trace_busy ? trace_nib : {state_d, 1'b0};
      halt_req  <= fire && (ctrl.resp == RESP_HALT);
      take_dbg  <= take_now;
      take_nmi  <= insn_sample && ext_nmi && !take_now;
    end
  end

  // R9: a halt request lasts a single cycle
  a_r9_halt_one_cycle: assert property (@(posedge clk) disable iff (rst)
    halt_req |=> !halt_req);

  // R8: a fired final state holds until reconfiguration
  a_r8_final_holds: assert property (@(posedge clk) disable iff (rst)
    ((state_q == ST_HIT1 || state_q == ST_HIT2) && !restart) |=> $stable(state_q));

  // R7: level 2 cannot fire straight from waiting for level 1
  a_r7_level2_armed_first: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_WAIT1) |=> (state_q != ST_HIT2));

  // R10: the debug interrupt is taken only at a sample point
  a_r10_take_at_sample: assert property (@(posedge clk) disable iff (rst)
    take_dbg |-> $past(insn_sample));

  // R11: a pending debug interrupt wins over the level-7 request
  a_r11_dbg_over_nmi: assert property (@(posedge clk) disable iff (rst)
    (pend_q && insn_sample && !restart) |=> (take_dbg && !take_nmi));
endmodule

// File: rtl/bkpt_trigger_unit.sv
module bkpt_trigger_unit
  import bkpt_pkg::*;
#(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int REG_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic [2:0]       cfg_addr,
  input  logic [REG_W-1:0] cfg_wdata,
  input  logic             insn_sample,
  input  logic [AW-1:0]    pc_in,
  input  logic             bus_valid,
  input  logic [AW-1:0]    bus_addr,
  input  logic [DW-1:0]    bus_data,
  input  logic             ext_nmi,
  input  logic             trace_busy,
  input  logic [3:0]       trace_nib,
  output logic [3:0]       ddata_out,
  output logic [REG_W-1:0] csr_status,
  output logic             halt_req,
  output logic             take_dbg,
  output logic             take_nmi
);
  localparam int PAD_W = REG_W - 4;

  bk_ctrl_t         ctrl, ctrl_new;
  logic             restart;
  logic [AW-1:0]    pc_ref, pc_mask, addr_lo, addr_hi;
  logic [DW-1:0]    data_ref, data_mask;
  logic [N_SRC-1:0] hits;
  logic [3:0]       code;

  bkpt_cfg_regs #(.AW(AW), .DW(DW), .REG_W(REG_W)) u_regs (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .ctrl(ctrl), .ctrl_new(ctrl_new),
    .restart(restart), .pc_ref(pc_ref), .pc_mask(pc_mask),
    .addr_lo(addr_lo), .addr_hi(addr_hi), .data_ref(data_ref),
    .data_mask(data_mask)
  );

  bkpt_match #(.AW(AW), .DW(DW)) u_match (
    .insn_sample(insn_sample), .pc_in(pc_in), .bus_valid(bus_valid),
    .bus_addr(bus_addr), .bus_data(bus_data), .pc_ref(pc_ref),
    .pc_mask(pc_mask), .addr_lo(addr_lo), .addr_hi(addr_hi),
    .data_ref(data_ref), .data_mask(data_mask), .hits(hits)
  );

  bkpt_seq u_seq (
    .clk(clk), .rst(rst), .restart(restart), .ctrl_new(ctrl_new),
    .ctrl(ctrl), .hits(hits), .insn_sample(insn_sample),
    .ext_nmi(ext_nmi), .trace_busy(trace_busy), .trace_nib(trace_nib),
    .code(code), .ddata_out(ddata_out), .halt_req(halt_req),
    .take_dbg(take_dbg), .take_nmi(take_nmi)
  );

  assign csr_status = {code, {PAD_W{1'b0}}};

  // R12: bit 0 of the reported code is always zero
  a_r12_code_lsb_zero: assert property (@(posedge clk) disable iff (rst)
    !csr_status[REG_W-4]);
endmodule

// File: tb/bkpt_trigger_unit_tb_top.sv
module bkpt_trigger_unit_tb_top;
  localparam int AW = 32, DW = 32, RW = 32;

  logic clk = 1'b0, rst = 1'b1;
  logic cfg_we = 1'b0;
  logic [2:0] cfg_addr = '0;
  logic [RW-1:0] cfg_wdata = '0;
  logic insn_sample = 1'b0, bus_valid = 1'b0, ext_nmi = 1'b0, trace_busy = 1'b0;
  logic [AW-1:0] pc_in = '0, bus_addr = '0;
  logic [DW-1:0] bus_data = '0;
  logic [3:0] trace_nib = '0;
  logic [3:0] ddata_out;
  logic [RW-1:0] csr_status;
  logic halt_req, take_dbg, take_nmi;

  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  bkpt_trigger_unit #(.AW(AW), .DW(DW), .REG_W(RW)) dut_i (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .insn_sample(insn_sample), .pc_in(pc_in),
    .bus_valid(bus_valid), .bus_addr(bus_addr), .bus_data(bus_data),
    .ext_nmi(ext_nmi), .trace_busy(trace_busy), .trace_nib(trace_nib),
    .ddata_out(ddata_out), .csr_status(csr_status), .halt_req(halt_req),
    .take_dbg(take_dbg), .take_nmi(take_nmi)
  );

  // reference model state
  logic [8:0] m_ctrl = '0;
  logic [AW-1:0] m_pref = '0, m_pmsk = '0, m_lo = '0, m_hi = '0;
  logic [DW-1:0] m_dref = '0, m_dmsk = '0;
  logic [2:0] m_st = 3'b000;
  logic m_pend = 1'b0;

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [2:0] bits_hit();
    logic [2:0] h;
    h[0] = insn_sample && (((pc_in ^ m_pref) & ~m_pmsk) == '0);
    h[1] = bus_valid && (bus_addr >= m_lo) && (bus_addr <= m_hi);
    h[2] = bus_valid && (((bus_data ^ m_dref) & ~m_dmsk) == '0);
    return h;
  endfunction

  // one clock with model prediction and output checks
  task automatic step(input string tag);
    logic [2:0] h, nst;
    logic fire, ifire, tnow, restart, e_halt, e_tnmi, npend;
    logic [3:0] e_dd;
    h = bits_hit();
    restart = cfg_we && cfg_addr == 3'd0;
    nst = m_st; fire = 1'b0;
    if (restart) nst = (|cfg_wdata[5:3]) ? 3'b001 : 3'b000;
    else if (m_st == 3'b001 && |(h & m_ctrl[5:3])) begin
      if (m_ctrl[2]) nst = 3'b101;
      else begin nst = 3'b010; fire = 1'b1; end
    end else if (m_st == 3'b101 && |(h & m_ctrl[8:6])) begin
      nst = 3'b110; fire = 1'b1;
    end
    ifire  = fire && m_ctrl[1:0] == 2'd2;
    e_halt = fire && m_ctrl[1:0] == 2'd1;
    tnow   = !restart && insn_sample && (m_pend || ifire);
    npend  = restart ? 1'b0 : ((m_pend || ifire) && !tnow);
    e_tnmi = insn_sample && ext_nmi && !tnow;
    if (rst) begin
      nst = 3'b000; npend = 1'b0; e_halt = 1'b0; tnow = 1'b0; e_tnmi = 1'b0;
    end
    e_dd = (trace_busy && !rst) ? trace_nib : {nst, 1'b0};
    @(posedge clk);
    #1;
    chk(tag, "ddata", {28'd0, ddata_out}, {28'd0, e_dd});
    chk(tag, "csr", csr_status, {nst, 1'b0, 28'd0});
    chk(tag, "halt", {31'd0, halt_req}, {31'd0, e_halt});
    chk(tag, "take_dbg", {31'd0, take_dbg}, {31'd0, tnow});
    chk(tag, "take_nmi", {31'd0, take_nmi}, {31'd0, e_tnmi});
    m_st = nst; m_pend = npend;
    if (rst) begin
      m_ctrl = '0; m_pref = '0; m_pmsk = '0; m_lo = '0; m_hi = '0; m_dref = '0; m_dmsk = '0;
    end else if (cfg_we) begin
      case (cfg_addr)
        3'd0: m_ctrl = cfg_wdata[8:0];
        3'd1: m_pref = cfg_wdata;
        3'd2: m_pmsk = cfg_wdata;
        3'd3: m_lo   = cfg_wdata;
        3'd4: m_hi   = cfg_wdata;
        3'd5: m_dref = cfg_wdata;
        3'd6: m_dmsk = cfg_wdata;
        default: ;
      endcase
    end
  endtask

  task automatic idle();
    cfg_we = 0; insn_sample = 0; bus_valid = 0; ext_nmi = 0; trace_busy = 0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d, input string tag);
    idle(); cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    step(tag);
    cfg_we = 0;
  endtask

  task automatic pc_cyc(input logic [31:0] pc, input string tag);
    idle(); insn_sample = 1; pc_in = pc; step(tag);
  endtask

  task automatic bus_cyc(input logic v, input logic [31:0] a, input logic [31:0] d, input string tag);
    idle(); bus_valid = v; bus_addr = a; bus_data = d; step(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    rst = 1; step("R1"); step("R1");
    rst = 0; idle(); step("R1");
    // R3 / R6 / R9: PC breakpoint with mask, halt response
    wr(3'd1, 32'h100, "R3"); wr(3'd2, 32'h00F, "R3");
    wr(3'd0, 32'h009, "R2");
    pc_cyc(32'h110, "R3");
    pc_cyc(32'h10F, "R9");
    pc_cyc(32'h100, "R8");
    idle(); step("R8");
    // R4 / R10 / R11: address window, interrupt, priority over level 7
    wr(3'd3, 32'h200, "R4"); wr(3'd4, 32'h2FF, "R4");
    wr(3'd0, 32'h012, "R2");
    bus_cyc(1, 32'h1FF, 0, "R4");
    bus_cyc(0, 32'h250, 0, "R4");
    bus_cyc(1, 32'h200, 0, "R10");
    idle(); step("R10");
    idle(); insn_sample = 1; ext_nmi = 1; pc_in = 0; step("R11");
    idle(); insn_sample = 1; ext_nmi = 1; step("R11");
    wr(3'd0, 32'h012, "R2");
    bus_cyc(1, 32'h300, 0, "R4");
    idle(); bus_valid = 1; bus_addr = 32'h2FF; insn_sample = 1; step("R10");
    // R7 / R5: two-level, PC then data
    wr(3'd5, 32'h0AB, "R5"); wr(3'd6, 32'h0F0, "R5");
    wr(3'd0, 32'h10D, "R7");
    bus_cyc(1, 32'h0, 32'h05B, "R7");
    pc_cyc(32'h101, "R7");
    bus_cyc(1, 32'h0, 32'h05C, "R5");
    bus_cyc(0, 32'h0, 32'h05B, "R5");
    bus_cyc(1, 32'h0, 32'h05B, "R7");
    pc_cyc(32'h101, "R8");
    // R13: no response selected
    wr(3'd0, 32'h008, "R13");
    pc_cyc(32'h100, "R13");
    // R12: trace nibble override
    idle(); trace_busy = 1; trace_nib = 4'h7; step("R12");
    // R2: no level-1 enable means off; restart drops pending
    wr(3'd0, 32'h000, "R2");
    wr(3'd0, 32'h012, "R2");
    bus_cyc(1, 32'h210, 0, "R10");
    wr(3'd0, 32'h012, "R2");
    idle(); insn_sample = 1; step("R2");
    // random mix
    for (int i = 0; i < 3000; i++) begin
      idle();
      if ($urandom_range(0, 19) == 0) begin
        cfg_we = 1; cfg_addr = 3'($urandom_range(0, 6));
        cfg_wdata = (cfg_addr == 3'd0) ? 32'($urandom_range(0, 511)) : 32'($urandom_range(0, 15));
      end
      insn_sample = 1'($urandom); bus_valid = 1'($urandom); ext_nmi = 1'($urandom);
      trace_busy = ($urandom_range(0, 7) == 0);
      trace_nib = 4'($urandom); pc_in = 32'($urandom_range(0, 15));
      bus_addr = 32'($urandom_range(0, 15)); bus_data = 32'($urandom_range(0, 15));
      step("R6");
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule